// File: doc/BRIEF.md
# Clock Register Bus Slave with Read Snapshot

This block is the two-wire serial slave that sits in front of a real-time clock register file. It watches an oversampled SCL/SDA pair, spots START and STOP, and accepts only transfers to its fixed 7-bit address. In a write, the first data byte sets the register pointer and every later byte goes to the register file through a one-cycle write strobe. In a read, bytes are shifted out MSB first from the pointer. The pointer advances after each byte and steps from the last register back to 00h.

The register file has ten byte slots. Slots 00h to 06h hold the time counters, which keep running on their own. Slots 07h to 09h are control registers. When a read address is accepted, the block takes a copy of all seven time bytes. It serves time reads from that copy, so a counter carry during a long burst cannot mix old and new fields. The copy is released, and reloaded from the live counters on that same cycle, when a STOP arrives or when a control slot is loaded for transmission. After release the copy follows the live counters again. The slave pulls SDA low through `sda_oe` and never stretches the clock.

Top module: `rtc_bus_slave`

## Requirements
- R1: After reset and after a STOP (SDA rising while SCL is high), the slave ignores all clocked bits until a START (SDA falling while SCL is high). A STOP ends any transfer and releases SDA.
- R2: The first byte after START is the address. Bits 7..1 are the device address 1101000 and bit 0 is the direction (0 = write, 1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it never pulls SDA low and writes nothing until the next START.
- R3: In a write, the byte after the address loads the pointer. Each later byte produces exactly one single-cycle `wr_en` pulse carrying the pointer and the byte, then the pointer advances. Every byte received is acknowledged.
- R4: The pointer steps from 09h to 00h, in both reads and writes.
- R5: A repeated START followed by a read address returns the byte at the pointer, MSB first. Slots 00h–06h are time bytes and slots 07h–09h are the `ctrl_rd` bytes.
- R6: A read with no pointer write first starts at the pointer left by the previous access.
- R7: A master ACK after a read byte makes the slave send the next byte. A master NACK makes the slave release SDA and stay silent until the next START.
- R8: From the acknowledged read address onward, time bytes are returned as they stood at that moment, even if the live counters change during the burst.
- R9: A STOP releases the snapshot, so a later read returns the updated counters.
- R10: Loading a control slot (07h–09h) for transmission releases the snapshot. Time bytes reached after the pointer wraps in that same burst show the live counters.
- R11: The slave changes its drive of SDA only while SCL is sampled low, apart from the release forced by START or STOP.
- R12: Out of reset, SDA is released and `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| time_live | input | 56 | Live time bytes; slot n occupies bits 8n+7..8n |
| ctrl_rd | input | 24 | Control bytes for slots 07h–09h; slot 07h+n occupies bits 8n+7..8n |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | 4 | Register slot being written |
| wr_data | output | 8 | Byte being written |

## Verification
The hardest case to reach is a change of the live counters that falls inside a read burst, after the snapshot is taken and before it is released. The bench owns the register file model and the master. It pauses the master between two byte reads and rewrites the time bytes there. It then checks that the rest of the burst still returns the earlier values. The same pause is used in a burst that runs through the control slots and wraps to 00h, which shows the release on a control read. A burst closed by STOP and then repeated shows the release on STOP.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WORD,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o    = scl_pipe[STAGES-1];
  assign sda_o    = sda_pipe[STAGES-1];
  assign scl_rise = scl_o & ~scl_q;
  assign scl_fall = ~scl_o & scl_q;
  // Data edges while the clock stays high form the framing conditions.
  assign start_o  = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o   = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/rtc_freeze_bank.sv
module rtc_freeze_bank #(
  parameter int N_BYTES = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_set,
  input  logic                  hold_clr,
  input  logic [N_BYTES*8-1:0]  live_i,
  output logic [N_BYTES*8-1:0]  view_o,
  output logic                  frozen_o
);
  logic frozen_q, frozen_d, load;

  always_comb begin
    frozen_d = frozen_q;
    if (hold_clr)      frozen_d = 1'b0;
    else if (hold_set) frozen_d = 1'b1;
  end

  // Copy tracks live while open; a release reloads it on the same edge.
  assign load = ~frozen_q | hold_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      view_o   <= '0;
    end else begin
      frozen_q <= frozen_d;
      for (int b = 0; b < N_BYTES; b++) begin
        if (load) view_o[b*8 +: 8] <= live_i[b*8 +: 8];
      end
    end
  end

  assign frozen_o = frozen_q;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import rtc_bus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         NREG     = 10,
  parameter int         PTR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] ptr_o,
  output logic             take_o,
  output logic             hold_set
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

  bus_st_e          st, st_n, ret, ret_n;
  logic [3:0]       cnt, cnt_n;
  logic [7:0]       sh, sh_n, tx, tx_n, wd_n;
  logic [PTR_W-1:0] ptr, ptr_n, wa_n, ptr_inc;
  logic             nack, nack_n, oe_n, wr_n, load_tx;

  assign ptr_inc = (ptr >= LAST) ? '0 : ptr + PTR_W'(1);

  always_comb begin
    st_n = st;  ret_n = ret;  cnt_n = cnt;  sh_n = sh;  tx_n = tx;
    ptr_n = ptr;  nack_n = nack;  oe_n = sda_oe;
    wr_n = 1'b0;  wa_n = wr_addr;  wd_n = wr_data;
    load_tx = 1'b0;  take_o = 1'b0;  hold_set = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end
          if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            st_n  = ST_ACK;
            oe_n  = 1'b1;
            if (st == ST_ADDR) begin
              if (sh[7:1] != DEV_ADDR) begin
                st_n = ST_IDLE;
                oe_n = 1'b0;
              end else if (sh[0]) begin
                ret_n    = ST_RDATA;
                hold_set = 1'b1;
              end else begin
                ret_n = ST_WORD;
              end
            end else if (st == ST_WORD) begin
              ptr_n = sh[PTR_W-1:0];
              ret_n = ST_WDATA;
            end else begin
              wr_n  = (ptr <= LAST);
              wa_n  = ptr;
              wd_n  = sh;
              ptr_n = ptr_inc;
              ret_n = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ret;
            if (ret == ST_RDATA) load_tx = 1'b1;
          end
        end
        ST_RDATA: begin
          if (scl_rise) cnt_n = cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              tx_n = {tx[6:0], 1'b0};
              oe_n = ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_n = sda_s;
          if (scl_fall) begin
            if (nack) st_n = ST_IDLE;
            else      load_tx = 1'b1;
          end
        end
        default: ;
      endcase
      if (load_tx) begin
        tx_n   = rd_byte;
        oe_n   = ~rd_byte[7];
        take_o = 1'b1;
        ptr_n  = ptr_inc;
        cnt_n  = '0;
        st_n   = ST_RDATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ret     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      st      <= st_n;
      ret     <= ret_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      tx      <= tx_n;
      ptr     <= ptr_n;
      nack    <= nack_n;
      sda_oe  <= oe_n;
      wr_en   <= wr_n;
      wr_addr <= wa_n;
      wr_data <= wd_n;
    end
  end

  assign ptr_o = ptr;
endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
  import rtc_bus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         N_TIME      = 7,
  parameter int         N_CTRL      = 3,
  parameter int         SYNC_STAGES = 2,
  localparam int        NREG        = N_TIME + N_CTRL,
  localparam int        PTR_W       = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic [N_TIME*BYTE_W-1:0]   time_live,
  input  logic [N_CTRL*BYTE_W-1:0]   ctrl_rd,
  output logic                       wr_en,
  output logic [PTR_W-1:0]           wr_addr,
  output logic [BYTE_W-1:0]          wr_data
);
  localparam int SLOTS = 2 ** PTR_W;

  logic [1:0]                 rst_pipe;
  logic                       rst_sn;
  logic                       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]           cur_ptr;
  logic                       rd_take, hold_set, hold_clr, frozen;
  logic [N_TIME*BYTE_W-1:0]   time_view;
  logic [BYTE_W-1:0]          slot [SLOTS];
  logic [BYTE_W-1:0]          rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ptr_o(cur_ptr), .take_o(rd_take), .hold_set(hold_set)
  );

  // Any control slot handed to the shifter ends the time snapshot.
  assign hold_clr = stop_det | (rd_take & (cur_ptr >= PTR_W'(N_TIME)));

  rtc_freeze_bank #(.N_BYTES(N_TIME)) u_freeze (
    .clk(clk), .rst_n(rst_sn), .hold_set(hold_set), .hold_clr(hold_clr),
    .live_i(time_live), .view_o(time_view), .frozen_o(frozen)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < N_TIME) begin : g_time
      assign slot[g] = time_view[g*BYTE_W +: BYTE_W];
    end else if (g < NREG) begin : g_ctrl
      assign slot[g] = ctrl_rd[(g-N_TIME)*BYTE_W +: BYTE_W];
    end else begin : g_none
      assign slot[g] = '0;
    end
  end

  assign rd_byte = slot[cur_ptr];
endmodule

// File: rtl/rtc_bus_slave_chk.sv
module rtc_bus_slave_chk #(
  parameter int NREG  = 10,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_addr,
  input logic             frozen
);
  p_sda_rise_lowscl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  p_sda_fall_lowscl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!$past(scl_s) || $past(stop_det) || $past(start_det)));

  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_wr_inrange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NREG));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !frozen);

  p_stop_sda_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind rtc_bus_slave rtc_bus_slave_chk #(.NREG(NREG), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
  .frozen(frozen)
);

// File: tb/test_rtc_bus_slave.sv
module test_rtc_bus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam int NREG       = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_line, sda_oe, wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [55:0] live;
  logic [23:0] ctrl;
  logic [7:0]  bank [NREG];
  int          exp_q[$];
  int          checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  always_comb begin
    for (int i = 0; i < 7; i++) live[i*8 +: 8] = bank[i];
    for (int i = 0; i < 3; i++) ctrl[i*8 +: 8] = bank[7+i];
  end

  rtc_bus_slave i_rtc_bus_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .time_live(live), .ctrl_rd(ctrl), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Register file model: every strobe must match the next expected write.
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) chk("R2/R3 unexpected write", {wr_addr, wr_data}, 0);
      else chk("R3/R4 write", int'({wr_addr, wr_data}), exp_q.pop_front());
      bank[wr_addr] = wr_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic qt(); repeat (QTR) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; qt(); m_scl = 1'b1; qt(); m_sda = 1'b0; qt(); m_scl = 1'b0; qt();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; qt(); m_scl = 1'b1; qt(); m_sda = 1'b1; qt(); qt();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qt(); m_scl = 1'b1; qt(); qt(); m_scl = 1'b0; qt();
    end
    m_sda = 1'b1; qt(); m_scl = 1'b1; qt(); ack = ~sda_line; qt(); m_scl = 1'b0; qt();
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; qt(); m_scl = 1'b1; qt(); d[i] = sda_line; qt(); m_scl = 1'b0; qt();
    end
    m_sda = nack; qt(); m_scl = 1'b1; qt(); qt(); m_scl = 1'b0; qt();
    m_sda = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    m_start();
    m_wbyte(8'hD0, a); chk("R2 address ack", a, 1);
    m_wbyte(p, a);     chk("R3 pointer ack", a, 1);
  endtask

  task automatic rd_start();
    logic a;
    m_start();
    m_wbyte(8'hD1, a); chk("R2 read address ack", a, 1);
  endtask

  initial begin
    logic       a;
    logic [7:0] d;
    logic [7:0] old [7];
    for (int i = 0; i < NREG; i++) bank[i] = 8'h10 + 8'(i);
    repeat (5) @(negedge clk);
    chk("R12 sda released", sda_oe, 0);
    chk("R12 no strobe", wr_en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: pointer write then three data bytes
    exp_q.push_back('h2A1); exp_q.push_back('h3B2); exp_q.push_back('h4C3);
    set_ptr(8'h02);
    m_wbyte(8'hA1, a); chk("R3 data ack", a, 1);
    m_wbyte(8'hB2, a); chk("R3 data ack", a, 1);
    m_wbyte(8'hC3, a); chk("R3 data ack", a, 1);
    m_stop();
    chk("R3 all writes seen", exp_q.size(), 0);

    // R2: foreign address is not acknowledged, data ignored
    m_start();
    m_wbyte(8'hA0, a); chk("R2 no ack foreign", a, 0);
    m_wbyte(8'h02, a); chk("R2 ignored byte", a, 0);
    m_wbyte(8'h55, a); chk("R2 ignored byte", a, 0);
    m_stop();
    chk("R2 bank intact", bank[2], 'hA1);

    // R1: clocked bits with no START are ignored
    m_wbyte(8'hD0, a); chk("R1 no ack without start", a, 0);
    m_wbyte(8'h03, a); chk("R1 ignored byte", a, 0);

    // R5, R7: random read of control slots, NACK on the last
    set_ptr(8'h07);
    rd_start();
    m_rbyte(1'b0, d); chk("R5 slot 07", d, 'h17);
    m_rbyte(1'b0, d); chk("R5 slot 08", d, 'h18);
    m_rbyte(1'b1, d); chk("R5 slot 09", d, 'h19);
    chk("R7 released after nack", sda_oe, 0);
    m_stop();

    // R4, R6: pointer wrapped to 00h by the read
    rd_start();
    m_rbyte(1'b1, d); chk("R6/R4 current read after wrap", d, 'h10);
    m_stop();
    exp_q.push_back('h95A); exp_q.push_back('h06B);
    set_ptr(8'h09);
    m_wbyte(8'h5A, a); chk("R4 data ack", a, 1);
    m_wbyte(8'h6B, a); chk("R4 data ack", a, 1);
    m_stop();
    chk("R4 wrap writes seen", exp_q.size(), 0);
    rd_start();
    m_rbyte(1'b1, d); chk("R6 current read slot 01", d, 'h11);
    m_stop();

    // R8: counters change mid burst, burst keeps the snapshot
    set_ptr(8'h00);
    rd_start();
    for (int i = 0; i < 7; i++) old[i] = bank[i];
    m_rbyte(1'b0, d); chk("R8 slot 00", d, int'(old[0]));
    for (int i = 0; i < 7; i++) bank[i] = bank[i] + 8'h20;
    for (int i = 1; i < 7; i++) begin
      m_rbyte(i == 6, d); chk("R8 frozen time byte", d, int'(old[i]));
    end
    m_stop();

    // R9: after STOP the new values are visible
    set_ptr(8'h00);
    rd_start();
    for (int i = 0; i < 7; i++) begin
      m_rbyte(i == 6, d); chk("R9 updated time byte", d, int'(bank[i]));
    end
    m_stop();

    // R10: reading a control slot releases the snapshot
    set_ptr(8'h05);
    rd_start();
    for (int i = 0; i < 7; i++) old[i] = bank[i];
    m_rbyte(1'b0, d); chk("R10 slot 05", d, int'(old[5]));
    for (int i = 0; i < 7; i++) bank[i] = bank[i] + 8'h01;
    m_rbyte(1'b0, d); chk("R10 slot 06 still frozen", d, int'(old[6]));
    m_rbyte(1'b0, d); chk("R10 slot 07", d, 'h17);
    m_rbyte(1'b0, d); chk("R10 slot 08", d, 'h18);
    m_rbyte(1'b0, d); chk("R10 slot 09", d, 'h5A);
    m_rbyte(1'b1, d); chk("R10 slot 00 live", d, int'(bank[0]));
    m_stop();

    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule